// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank State Tracking

This block watches the control and address pins of a double-data-rate SDRAM command bus and, on every rising clock edge, turns the pin pattern into a named command. It follows each of the four banks through three states: idle, open, and closing under auto-precharge. It also remembers the row that was last opened in each bank. A controller or protocol monitor can use it to see which banks are open and to catch command sequences that break the bank rules.

Bit 10 of the address has two uses. On a read or write, it schedules an automatic close of the bank when the burst ends. On a precharge, it widens the close to every bank. A refresh leaves every bank idle. The block accepts a refresh only when all banks are already idle. A command that breaks a bank rule raises a one-cycle flag and changes no state.

Commands are decoded from chip select, row strobe, column strobe, write enable and clock enable. All of these are active low except clock enable. Pin values below are written as {row strobe, column strobe, write enable}.

Bank states:
- BK_IDLE: the bank is closed.
- BK_OPEN: a row is open in the bank.
- BK_CLOSING: an auto-precharge countdown is running.

Bank transitions:
- OPEN_ROW: BK_IDLE to BK_OPEN, on an accepted ACT.
- ARM_AUTOCLOSE: BK_OPEN to BK_CLOSING, on an accepted READ or WRITE with address bit 10 high.
- CLOSE_NOW: BK_OPEN or BK_CLOSING to BK_IDLE, on a PRE to this bank or on PREA.
- BURST_DONE: BK_CLOSING to BK_IDLE, when the countdown runs out.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The command decoded at a rising edge appears on `cmd_o` after that edge. The codes are DESEL=0, NOP=1, ACT=2, READ=3, WRITE=4, PRE=5, PREA=6, REF=7 and OTHER=8.
  - Chip select high gives DESEL, whatever the other pins are.
  - With chip select low, {row, column, write} = 111 is NOP, 011 is ACT, 101 is READ, 100 is WRITE, 010 is PRE (PREA when address bit 10 is high), and 001 with clock enable high is REF.
  - Every other pattern is OTHER, and OTHER has no effect on any bank.
- R2: An ACT to a BK_IDLE bank moves it to BK_OPEN, which sets `bank_active_o[b]`. The row address bits appear on `open_rows_o[12*b +: 12]`.
- R3: An ACT to a bank that is not BK_IDLE raises `illegal_o` and changes neither the bank states nor the stored rows.
- R4: A READ or WRITE to a bank that is not BK_OPEN raises `illegal_o` and changes no bank state.
- R5: A READ or WRITE with address bit 10 low leaves the bank BK_OPEN. With bit 10 high, the bank is still active through the first BURST_CYC-1 edges after the command edge and reads idle after edge BURST_CYC (default 4).
- R6: A PRE with bit 10 low closes only the addressed bank, whether it is open or closing. PRE is never flagged as illegal.
- R7: A PRE with bit 10 high (PREA) closes all four banks.
- R8: A REF while all banks are idle is accepted and leaves them idle. A REF while any bank is active raises `illegal_o`.
- R9: `all_idle_o` is high exactly when `bank_active_o` is zero.
- R10: After reset:
  - `cmd_o` is DESEL, `illegal_o` is 0, every bank is idle and every stored row is 0.
  - `illegal_o` is high only in the cycle after the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; distinguishes auto-refresh from other patterns |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address; bit 10 is the auto-precharge / all-bank option |
| cmd_o | output | 4 | Decoded command code of the last edge |
| illegal_o | output | 1 | The last command broke a bank rule |
| bank_active_o | output | 4 | One bit per bank, set when the bank is not idle |
| all_idle_o | output | 1 | No bank is active |
| open_rows_o | output | 48 | Stored row per bank, 12 bits each, bank 0 lowest |

## Verification
The bench runs ACTs to idle and to open banks, and reads and writes to idle, open and closing banks. This separates the legal-command path from the illegal-command path per bank state. Reads and writes are issued with bit 10 both low and high, and the bank is watched edge by edge through the countdown, which pins down exactly when the auto-close takes effect. Precharges are issued to a single bank, to all banks, and to a bank whose countdown is still running. Refresh is issued with banks busy and with all banks idle. Deselected, low clock-enable and mode-register patterns are then sent, to show that they leave the state untouched.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_READ  = 4'd3,
        CMD_WRITE = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_PREA  = 4'd6,
        CMD_REF   = 4'd7,
        CMD_OTHER = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic opt_bit,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_OTHER;
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = opt_bit ? CMD_PREA : CMD_PRE;
                3'b001:  cmd = cke ? CMD_REF : CMD_OTHER;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int BURST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             accept,
    input  cmd_e             cmd,
    input  logic             opt_bit,
    input  logic [ROW_W-1:0] row_in,
    output bank_st_e         st,
    output logic [ROW_W-1:0] row_o
);

    localparam int CNT_W = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_CYC - 1);

    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;

    logic close_req;
    logic col_req;

    assign close_req = (cmd == CMD_PREA) || (cmd == CMD_PRE && hit);
    assign col_req   = (cmd == CMD_READ || cmd == CMD_WRITE) && hit && accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            row_q <= row_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        row_d = row_q;
        unique case (st_q)
            BK_IDLE: begin
                if (cmd == CMD_ACT && hit && accept) begin
                    st_d  = BK_OPEN;          // OPEN_ROW
                    row_d = row_in;
                end
            end
            BK_OPEN: begin
                if (close_req) begin
                    st_d = BK_IDLE;           // CLOSE_NOW
                end else if (col_req && opt_bit) begin
                    st_d  = BK_CLOSING;       // ARM_AUTOCLOSE
                    cnt_d = CNT_LOAD;
                end
            end
            BK_CLOSING: begin
                if (close_req) begin
                    st_d = BK_IDLE;           // CLOSE_NOW
                end else if (cnt_q == '0) begin
                    st_d = BK_IDLE;           // BURST_DONE
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    assign st    = st_q;
    assign row_o = row_q;

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int OPT_BIT   = 10,
    parameter int BURST_CYC = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [3:0]                 cmd_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_active_o,
    output logic                       all_idle_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o
);

    cmd_e     cmd_now;
    cmd_e     cmd_q;
    logic     bad_now;
    logic     illegal_q;
    bank_st_e st_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0] active_now;

    sdram_cmd_decode u_dec (
        .cke     (cke),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .opt_bit (addr[OPT_BIT]),
        .cmd     (cmd_now)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        sdram_bank_fsm #(
            .ROW_W     (ROW_W),
            .BURST_CYC (BURST_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (ba == BA_W'(gi)),
            .accept  (!bad_now),
            .cmd     (cmd_now),
            .opt_bit (addr[OPT_BIT]),
            .row_in  (addr),
            .st      (st_arr[gi]),
            .row_o   (open_rows_o[gi*ROW_W +: ROW_W])
        );
        assign active_now[gi] = (st_arr[gi] != BK_IDLE);
    end

    // rule check against the addressed bank's current state
    always_comb begin
        unique case (cmd_now)
            CMD_ACT:            bad_now = (st_arr[ba] != BK_IDLE);
            CMD_READ,
            CMD_WRITE:          bad_now = (st_arr[ba] != BK_OPEN);
            CMD_REF:            bad_now = |active_now;
            default:            bad_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_DESEL;
            illegal_q <= 1'b0;
        end else begin
            cmd_q     <= cmd_now;
            illegal_q <= bad_now;
        end
    end

    assign cmd_o         = cmd_q;
    assign illegal_o     = illegal_q;
    assign bank_active_o = active_now;
    assign all_idle_o    = ~|active_now;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int BA_W      = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_n,
    input logic [BA_W-1:0]            ba,
    input logic [ROW_W-1:0]           addr,
    input logic [3:0]                 cmd_o,
    input logic                       illegal_o,
    input logic [NUM_BANKS-1:0]       bank_active_o,
    input logic                       all_idle_o,
    input logic [NUM_BANKS*ROW_W-1:0] open_rows_o
);

    assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (cmd_o == CMD_DESEL));

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !illegal_o) |->
            (bank_active_o[$past(ba)] &&
             open_rows_o[$past(ba)*ROW_W +: ROW_W] == $past(addr)));

    assert_rows_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_o == CMD_ACT && !illegal_o) |-> $stable(open_rows_o));

    assert_prea_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PREA) |-> all_idle_o);

    assert_ref_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF && !illegal_o) |-> (all_idle_o && bank_active_o == '0));

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cmd_o == CMD_ACT || cmd_o == CMD_READ ||
                       cmd_o == CMD_WRITE || cmd_o == CMD_REF));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .BA_W      (BA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .ba            (ba),
    .addr          (addr),
    .cmd_o         (cmd_o),
    .illegal_o     (illegal_o),
    .bank_active_o (bank_active_o),
    .all_idle_o    (all_idle_o),
    .open_rows_o   (open_rows_o)
);

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/100ps
module sdram_cmd_tracker_tb;

    localparam int BURST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [3:0]  cmd_o;
    logic        illegal_o;
    logic [3:0]  bank_active_o;
    logic        all_idle_o;
    logic [47:0] open_rows_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .illegal_o(illegal_o), .bank_active_o(bank_active_o),
        .all_idle_o(all_idle_o), .open_rows_o(open_rows_o)
    );

    typedef struct {
        string       tag;
        int          cmd;
        bit          ill;
        logic [3:0]  act;
        logic [47:0] rows;
    } exp_t;

    exp_t q[$];

    // requirement model
    int          m_st [4];
    int          m_cn [4];
    logic [11:0] m_row [4];

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input string tag, input bit c, input bit r, input bit ca,
                         input bit w, input bit ck, input logic [1:0] b, input logic [11:0] a);
        exp_t e;
        int   code;
        bit   ill;
        bit   anyact;
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = ck; ba = b; addr = a;
        if (c) code = 0;
        else case ({r, ca, w})
            3'b111: code = 1;
            3'b011: code = 2;
            3'b101: code = 3;
            3'b100: code = 4;
            3'b010: code = a[10] ? 6 : 5;
            3'b001: code = ck ? 7 : 8;
            default: code = 8;
        endcase
        anyact = 0;
        for (int i = 0; i < 4; i++) if (m_st[i] != 0) anyact = 1;
        ill = (code == 2 && m_st[b] != 0) || ((code == 3 || code == 4) && m_st[b] != 1) ||
              (code == 7 && anyact);
        for (int i = 0; i < 4; i++) begin
            bit hit;
            hit = (b == 2'(i));
            if (m_st[i] == 2) begin
                if ((code == 5 && hit) || code == 6) m_st[i] = 0;
                else if (m_cn[i] == 0) m_st[i] = 0;
                else m_cn[i]--;
            end else if (m_st[i] == 1) begin
                if ((code == 5 && hit) || code == 6) m_st[i] = 0;
                else if ((code == 3 || code == 4) && hit && !ill && a[10]) begin
                    m_st[i] = 2; m_cn[i] = BURST - 1;
                end
            end else if (code == 2 && hit && !ill) begin
                m_st[i] = 1; m_row[i] = a;
            end
        end
        e.tag = tag; e.cmd = code; e.ill = ill;
        for (int i = 0; i < 4; i++) begin
            e.act[i] = (m_st[i] != 0);
            e.rows[i*12 +: 12] = m_row[i];
        end
        q.push_back(e);
    endtask

    task automatic nop(input string tag);
        issue(tag, 0, 1, 1, 1, 1, 2'd0, 12'h000);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "cmd_o", cmd_o, e.cmd);
                chk(e.tag, "illegal_o", illegal_o, e.ill);
                chk(e.tag, "bank_active_o", bank_active_o, e.act);
                chk({e.tag, "/R9"}, "all_idle_o", all_idle_o, (e.act == 4'b0));
                chk(e.tag, "open_rows_o", open_rows_o, e.rows);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_cn[i] = 0; m_row[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10", "cmd_o", cmd_o, 0);
        chk("R10", "illegal_o", illegal_o, 0);
        chk("R10", "bank_active_o", bank_active_o, 0);
        chk("R10", "all_idle_o", all_idle_o, 1);
        chk("R10", "open_rows_o", open_rows_o, 0);
        @(negedge clk) rst_n = 1'b1;

        issue("R1 desel", 1, 0, 0, 0, 1, 2'd0, 12'h000);
        nop("R1 nop");
        issue("R2 act b0", 0, 0, 1, 1, 1, 2'd0, 12'h123);
        issue("R2 act b2", 0, 0, 1, 1, 1, 2'd2, 12'hABC);
        issue("R3 act open b0", 0, 0, 1, 1, 1, 2'd0, 12'h555);
        issue("R4 read idle b1", 0, 1, 0, 1, 1, 2'd1, 12'h000);
        issue("R5 write b0 no ap", 0, 1, 0, 0, 1, 2'd0, 12'h000);
        issue("R5 read b2 ap", 0, 1, 0, 1, 1, 2'd2, 12'h400);
        issue("R4 write closing b2", 0, 1, 0, 0, 1, 2'd2, 12'h000);
        nop("R5 countdown");
        nop("R5 countdown");
        nop("R5 close edge");
        issue("R8 ref busy", 0, 0, 0, 1, 1, 2'd0, 12'h000);
        issue("R6 pre b0", 0, 0, 1, 0, 1, 2'd0, 12'h000);
        issue("R8 ref idle", 0, 0, 0, 1, 1, 2'd0, 12'h000);
        issue("R2 act b1 max row", 0, 0, 1, 1, 1, 2'd1, 12'hFFF);
        issue("R2 act b3", 0, 0, 1, 1, 1, 2'd3, 12'h0F0);
        issue("R6 pre idle b0", 0, 0, 1, 0, 1, 2'd0, 12'h000);
        issue("R7 prea", 0, 0, 1, 0, 1, 2'd2, 12'h400);
        issue("R2 act b3 again", 0, 0, 1, 1, 1, 2'd3, 12'h321);
        issue("R5 write b3 ap", 0, 1, 0, 0, 1, 2'd3, 12'h400);
        nop("R5 closing");
        issue("R6 pre closing b3", 0, 0, 1, 0, 1, 2'd3, 12'h000);
        issue("R2 act b0", 0, 0, 1, 1, 1, 2'd0, 12'h777);
        issue("R1 desel act pins", 1, 0, 1, 1, 1, 2'd1, 12'h111);
        issue("R1 ref cke low other", 0, 0, 0, 1, 0, 2'd0, 12'h000);
        issue("R1 mode set other", 0, 0, 0, 0, 1, 2'd0, 12'h000);
        issue("R5 read b0 no ap", 0, 1, 0, 1, 1, 2'd0, 12'h000);
        nop("R5 stays open");
        nop("R5 stays open");
        nop("R5 stays open");
        nop("R5 stays open");
        issue("R3 act b0 open", 0, 0, 1, 1, 1, 2'd0, 12'h999);
        nop("R10 flag one cycle");
        nop("drain");
        while (q.size() > 0) @(posedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule